// File: doc/BRIEF.md
# System Controller with GPIO Bank and Compare Timers

This peripheral sits on a simple 32-bit register bus and gathers the small housekeeping functions of a chip: a bank of general-purpose inputs and outputs with a change interrupt, and two identical up-counting timers. It also has a command word that can request a shutdown, and read-only words that report capabilities and a system identifier. Software selects a register by word index, which is the byte address shifted right by two. Reads are combinational on the address. A write takes effect at the next rising clock edge.

Each timer counts up by one per clock cycle while enabled. When its counter equals its compare value, the timer emits a one-cycle interrupt pulse. After that hit it either stops and clears its own enable bit (one-shot), or returns its counter to zero and keeps going (auto-restart). A write of the shutdown code to the command word, or any write to the identifier word, produces a one-cycle request strobe for the power and reset logic outside the block.

Top module: `soc_ctrl_unit`

## Requirements
- R1: Word index = bus_addr[5:2]. Index map: 0 input bank, 1 output bank, 2 interrupt enable, 4/5/6 timer0 control/compare/counter, 8/9/10 timer1 control/compare/counter, 13 command/status, 14 capabilities, 15 identifier. Indices 3, 7, 11 and 12 read 0, and writes to them change nothing.
- R2: A write is accepted only when bus_be is 4'hF and bus_addr[1:0] is 0. Any other write leaves every register unchanged.
- R3: After reset, index 0 reads the strap value (default 1), index 13 reads 1, index 14 reads 0, index 15 reads 32'h10014D31, every other index reads 0, and all outputs are low.
- R4: Indices 1 and 2 read back the low GPIO_W bits written to them, and gpio_out follows index 1 one cycle after the write. Index 0 shows gpio_in through a two-stage synchronizer, so a pin change is readable two cycles after it is applied. Writes to index 0 are ignored.
- R5: irq_gpio pulses for one cycle, three cycles after a pin change, when a changed bit has its bit set in index 2. A change on a bit whose enable is clear gives no pulse.
- R6: Timer control bit 0 is enable. While enabled, the counter increments once per cycle. When the counter equals the compare value, the timer's irq output is high in the following cycle. A timer enabled at counter S with compare C pulses C-S+2 cycles after the enabling write.
- R7: Control bit 1 is auto-restart. With bit 1 clear, a hit clears enable (index 4 or 8 reads 0) and the counter holds at the compare value.
- R8: With auto-restart set, the counter reads 0 in the cycle after a hit, and interrupts repeat every compare+1 cycles.
- R9: Clearing enable freezes the counter after the edge that captures the write. Software may load the counter, and setting enable resumes counting from the loaded value.
- R10: A write to index 13 whose bits [15:0] equal 16'h000E gives a one-cycle shutdown_req pulse in the next cycle. Any other value gives none. Index 13 always reads 1.
- R11: Any write to index 15 gives a one-cycle reset_req pulse in the next cycle. Indices 14 and 15 are not changed by writes, and a write to index 14 raises no request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; also the timer count clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 6 | Byte address of the access |
| bus_wr | input | 1 | Write strobe, one write per cycle |
| bus_be | input | 4 | Byte enables; only all-ones is a valid write |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| gpio_in | input | GPIO_W | Asynchronous input pins |
| gpio_out | output | GPIO_W | Output bank value |
| irq_gpio | output | 1 | Input-change interrupt pulse |
| irq_timer0 | output | 1 | Timer 0 compare interrupt pulse |
| irq_timer1 | output | 1 | Timer 1 compare interrupt pulse |
| shutdown_req | output | 1 | Shutdown request strobe |
| reset_req | output | 1 | System reset request strobe |

## Verification
The hardest case to reach is a software write to a timer that lands close to a hit. One example is disabling an auto-restarting timer a few cycles before its next compare match, where the last increment happens on the same edge that captures the write. The stimulus runs timer 1 with a small compare value and reads its counter in specific cycles counted from the enabling write. It then stops the timer at a known cycle and checks three things: the frozen value, the absence of the interrupt that would otherwise have come, and a resumed count from a loaded counter value.

// File: rtl/soc_ctrl_pkg.sv
package soc_ctrl_pkg;

    localparam int DATA_W   = 32;
    localparam int REG_IX_W = 4;
    localparam int ADDR_W   = REG_IX_W + 2;
    localparam int N_TMR    = 2;

    typedef enum logic [REG_IX_W-1:0] {
        IX_PIN_IN   = 4'd0,
        IX_PIN_OUT  = 4'd1,
        IX_PIN_MASK = 4'd2,
        IX_T0_CTRL  = 4'd4,
        IX_T0_CMP   = 4'd5,
        IX_T0_CNT   = 4'd6,
        IX_T1_CTRL  = 4'd8,
        IX_T1_CMP   = 4'd9,
        IX_T1_CNT   = 4'd10,
        IX_CMD      = 4'd13,
        IX_CAPS     = 4'd14,
        IX_IDENT    = 4'd15
    } reg_ix_e;

    typedef struct packed {
        logic restart;
        logic run;
    } tmr_ctrl_t;

    typedef struct packed {
        logic                ok;
        logic [REG_IX_W-1:0] ix;
        logic [DATA_W-1:0]   data;
    } bus_wr_t;

    localparam logic [15:0] SHUTDOWN_CODE = 16'h000E;
    localparam logic [DATA_W-1:0] CMD_READY = 32'h1;

    function automatic logic full_word(input logic [3:0] be, input logic [1:0] lsb);
        return (be == 4'hF) && (lsb == 2'b00);
    endfunction

    function automatic logic [REG_IX_W-1:0] tmr_base(input int unsigned n);
        return REG_IX_W'(4 + 4 * n);
    endfunction

endpackage

// File: rtl/soc_ctrl_timer.sv
module soc_ctrl_timer
    import soc_ctrl_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_ctrl,
    input  logic              wr_cmp,
    input  logic              wr_cnt,
    input  logic [DATA_W-1:0] wdata,
    output tmr_ctrl_t         ctrl_o,
    output logic [DATA_W-1:0] cmp_o,
    output logic [DATA_W-1:0] cnt_o,
    output logic              irq_o
);
    tmr_ctrl_t         ctrl_q;
    logic [DATA_W-1:0] cmp_q;
    logic [DATA_W-1:0] cnt_q;
    logic              irq_q;
    logic              hit;

    assign hit = ctrl_q.run && (cnt_q == cmp_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= '0;
            cmp_q  <= '0;
            cnt_q  <= '0;
            irq_q  <= 1'b0;
        end else begin
            irq_q <= hit;
            if (wr_cmp)
                cmp_q <= wdata;
            if (wr_cnt)
                cnt_q <= wdata;
            else if (hit) begin
                if (ctrl_q.restart)
                    cnt_q <= '0;
            end else if (ctrl_q.run)
                cnt_q <= cnt_q + 1'b1;
            if (wr_ctrl)
                ctrl_q <= '{restart: wdata[1], run: wdata[0]};
            else if (hit && !ctrl_q.restart)
                ctrl_q.run <= 1'b0;
        end
    end

    assign ctrl_o = ctrl_q;
    assign cmp_o  = cmp_q;
    assign cnt_o  = cnt_q;
    assign irq_o  = irq_q;

    // R7: a one-shot hit drops the enable bit
    p_oneshot_stop_r7: assert property (@(posedge clk) disable iff (rst)
        (ctrl_q.run && !ctrl_q.restart && cnt_q == cmp_q && !wr_ctrl) |=> !ctrl_q.run);

    // R8: an auto-restart hit returns the counter to zero
    p_restart_zero_r8: assert property (@(posedge clk) disable iff (rst)
        (ctrl_q.run && ctrl_q.restart && cnt_q == cmp_q && !wr_cnt) |=> (cnt_q == '0));

    // R9: a stopped counter only moves on a software load
    p_freeze_r9: assert property (@(posedge clk) disable iff (rst)
        (!ctrl_q.run && !wr_cnt) |=> $stable(cnt_q));

    // R6: an interrupt follows a match of a running counter
    p_irq_cause_r6: assert property (@(posedge clk) disable iff (rst)
        irq_q |-> $past(ctrl_q.run && cnt_q == cmp_q));
endmodule

// File: rtl/soc_ctrl_gpio.sv
module soc_ctrl_gpio
    import soc_ctrl_pkg::*;
#(
    parameter int                GPIO_W = 8,
    parameter logic [GPIO_W-1:0] STRAP  = '0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [GPIO_W-1:0] pins,
    input  logic              wr_out,
    input  logic              wr_mask,
    input  logic [GPIO_W-1:0] wdata,
    output logic [GPIO_W-1:0] in_o,
    output logic [GPIO_W-1:0] out_o,
    output logic [GPIO_W-1:0] mask_o,
    output logic              irq_o
);
    logic [GPIO_W-1:0] sync_a, sync_b, prev_q, out_q, mask_q;
    logic              irq_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sync_a <= STRAP;
            sync_b <= STRAP;
            prev_q <= STRAP;
            out_q  <= '0;
            mask_q <= '0;
            irq_q  <= 1'b0;
        end else begin
            sync_a <= pins;
            sync_b <= sync_a;
            prev_q <= sync_b;
            irq_q  <= |((sync_b ^ prev_q) & mask_q);
            if (wr_out)
                out_q <= wdata;
            if (wr_mask)
                mask_q <= wdata;
        end
    end

    assign in_o   = sync_b;
    assign out_o  = out_q;
    assign mask_o = mask_q;
    assign irq_o  = irq_q;

    // R5: no change interrupt while every enable bit was clear
    p_gpio_irq_mask_r5: assert property (@(posedge clk) disable iff (rst)
        irq_q |-> $past(|mask_q));
endmodule

// File: rtl/soc_ctrl_unit.sv
module soc_ctrl_unit
    import soc_ctrl_pkg::*;
#(
    parameter int                GPIO_W      = 8,
    parameter logic [DATA_W-1:0] GPIO_STRAP  = 32'h0000_0001,
    parameter logic [DATA_W-1:0] CAPS_WORD   = 32'h0000_0000,
    parameter logic [DATA_W-1:0] IDENT_WORD  = 32'h1001_4D31
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [3:0]        bus_be,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic [GPIO_W-1:0] gpio_in,
    output logic [GPIO_W-1:0] gpio_out,
    output logic              irq_gpio,
    output logic              irq_timer0,
    output logic              irq_timer1,
    output logic              shutdown_req,
    output logic              reset_req
);
    bus_wr_t           wr;
    logic [REG_IX_W-1:0] rd_ix;
    logic [GPIO_W-1:0] pin_in, pin_out, pin_mask;
    tmr_ctrl_t         t_ctrl [N_TMR];
    logic [DATA_W-1:0] t_cmp  [N_TMR];
    logic [DATA_W-1:0] t_cnt  [N_TMR];
    logic [N_TMR-1:0]  t_irq;
    logic              shut_q, rstreq_q;

    assign wr.ok   = bus_wr && full_word(bus_be, bus_addr[1:0]);
    assign wr.ix   = bus_addr[ADDR_W-1:2];
    assign wr.data = bus_wdata;
    assign rd_ix   = bus_addr[ADDR_W-1:2];

    soc_ctrl_gpio #(.GPIO_W(GPIO_W), .STRAP(GPIO_STRAP[GPIO_W-1:0])) u_gpio (
        .clk     (clk),
        .rst     (rst),
        .pins    (gpio_in),
        .wr_out  (wr.ok && wr.ix == IX_PIN_OUT),
        .wr_mask (wr.ok && wr.ix == IX_PIN_MASK),
        .wdata   (wr.data[GPIO_W-1:0]),
        .in_o    (pin_in),
        .out_o   (pin_out),
        .mask_o  (pin_mask),
        .irq_o   (irq_gpio)
    );

    for (genvar n = 0; n < N_TMR; n++) begin : g_tmr
        localparam logic [REG_IX_W-1:0] BASE = tmr_base(n);
        soc_ctrl_timer u_tmr (
            .clk     (clk),
            .rst     (rst),
            .wr_ctrl (wr.ok && wr.ix == BASE),
            .wr_cmp  (wr.ok && wr.ix == BASE + 4'd1),
            .wr_cnt  (wr.ok && wr.ix == BASE + 4'd2),
            .wdata   (wr.data),
            .ctrl_o  (t_ctrl[n]),
            .cmp_o   (t_cmp[n]),
            .cnt_o   (t_cnt[n]),
            .irq_o   (t_irq[n])
        );
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            shut_q   <= 1'b0;
            rstreq_q <= 1'b0;
        end else begin
            shut_q   <= wr.ok && wr.ix == IX_CMD && wr.data[15:0] == SHUTDOWN_CODE;
            rstreq_q <= wr.ok && wr.ix == IX_IDENT;
        end
    end

    always_comb begin
        bus_rdata = '0;
        if (bus_addr[1:0] == 2'b00) begin
            case (rd_ix)
                IX_PIN_IN:   bus_rdata[GPIO_W-1:0] = pin_in;
                IX_PIN_OUT:  bus_rdata[GPIO_W-1:0] = pin_out;
                IX_PIN_MASK: bus_rdata[GPIO_W-1:0] = pin_mask;
                IX_T0_CTRL:  bus_rdata[1:0] = t_ctrl[0];
                IX_T0_CMP:   bus_rdata = t_cmp[0];
                IX_T0_CNT:   bus_rdata = t_cnt[0];
                IX_T1_CTRL:  bus_rdata[1:0] = t_ctrl[1];
                IX_T1_CMP:   bus_rdata = t_cmp[1];
                IX_T1_CNT:   bus_rdata = t_cnt[1];
                IX_CMD:      bus_rdata = CMD_READY;
                IX_CAPS:     bus_rdata = CAPS_WORD;
                IX_IDENT:    bus_rdata = IDENT_WORD;
                default:     bus_rdata = '0;
            endcase
        end
    end

    assign gpio_out     = pin_out;
    assign irq_timer0   = t_irq[0];
    assign irq_timer1   = t_irq[1];
    assign shutdown_req = shut_q;
    assign reset_req    = rstreq_q;

    // R10: shutdown only after an accepted write of the code
    p_shutdown_cause_r10: assert property (@(posedge clk) disable iff (rst)
        shutdown_req |-> $past(bus_wr && bus_be == 4'hF && bus_addr == {IX_CMD, 2'b00}
                               && bus_wdata[15:0] == 16'h000E));

    // R11: reset request only after an accepted identifier write
    p_reset_cause_r11: assert property (@(posedge clk) disable iff (rst)
        reset_req |-> $past(bus_wr && bus_be == 4'hF && bus_addr == {IX_IDENT, 2'b00}));

    // R2: a partial or misaligned write leaves the output bank alone
    p_partial_ignored_r2: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && (bus_be != 4'hF || bus_addr[1:0] != 2'b00)) |=> $stable(gpio_out));
endmodule

// File: tb/test_soc_ctrl_unit.sv
module test_soc_ctrl_unit;
    localparam int GW = 8;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [5:0]  bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic [3:0]  bus_be = 4'hF;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [GW-1:0] gpio_in = 8'h01;
    logic [GW-1:0] gpio_out;
    logic irq_gpio, irq_timer0, irq_timer1, shutdown_req, reset_req;

    soc_ctrl_unit #(.GPIO_W(GW)) i_soc_ctrl_unit (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_be(bus_be), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .gpio_in(gpio_in), .gpio_out(gpio_out), .irq_gpio(irq_gpio),
        .irq_timer0(irq_timer0), .irq_timer1(irq_timer1),
        .shutdown_req(shutdown_req), .reset_req(reset_req)
    );

    always #2 clk = ~clk;

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    typedef struct {
        int          due;
        int          sel;
        logic [31:0] exp;
        string       tag;
    } item_t;

    item_t sb[$];
    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;
    int wcyc = 0;

    function automatic logic [31:0] probe(int sel);
        case (sel)
            0: return bus_rdata;
            1: return {31'b0, irq_timer0};
            2: return {31'b0, irq_timer1};
            3: return {31'b0, irq_gpio};
            4: return {31'b0, shutdown_req};
            5: return {31'b0, reset_req};
            default: return {24'b0, gpio_out};
        endcase
    endfunction

    task automatic expect_at(int due, int sel, logic [31:0] exp, string tag);
        item_t it;
        it.due = due; it.sel = sel; it.exp = exp; it.tag = tag;
        sb.push_back(it);
    endtask

    // monitor: compares due items away from the active edge
    always @(negedge clk) begin
        item_t keep[$];
        logic [31:0] got;
        keep = {};
        foreach (sb[i]) begin
            if (sb[i].due == cyc) begin
                got = probe(sb[i].sel);
                n_chk++;
                if (got !== sb[i].exp) begin
                    n_fail++;
                    $display("FAIL %s cycle %0d: got %h expected %h", sb[i].tag, cyc, got, sb[i].exp);
                end
            end else begin
                keep.push_back(sb[i]);
            end
        end
        sb = keep;
    end

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic wr(int ix, logic [31:0] d, logic [3:0] be = 4'hF, logic [1:0] off = 2'b00);
        bus_wr = 1'b1;
        bus_addr = {ix[3:0], off};
        bus_wdata = d;
        bus_be = be;
        wcyc = cyc;
        step();
        bus_wr = 1'b0;
        bus_be = 4'hF;
    endtask

    task automatic rd(int ix, logic [31:0] exp, string tag);
        bus_addr = {ix[3:0], 2'b00};
        expect_at(cyc, 0, exp, tag);
        step();
    endtask

    initial begin
        int k;
        repeat (3) step();
        rst = 1'b0;
        step();

        // R3 reset values
        rd(0, 32'h1, "R3 strap in idx0");
        rd(13, 32'h1, "R3 status idx13");
        rd(14, 32'h0, "R3 caps idx14");
        rd(15, 32'h10014D31, "R3 ident idx15");
        for (int i = 1; i < 13; i++) rd(i, 32'h0, "R3 zero reg");
        expect_at(cyc, 1, 0, "R3 irq_timer0 low");
        expect_at(cyc, 2, 0, "R3 irq_timer1 low");
        expect_at(cyc, 3, 0, "R3 irq_gpio low");
        expect_at(cyc, 4, 0, "R3 shutdown low");
        expect_at(cyc, 5, 0, "R3 reset_req low");
        expect_at(cyc, 6, 0, "R3 gpio_out low");
        step();

        // R4 output and mask banks
        wr(1, 32'hFFFF_FFA5);
        expect_at(wcyc + 1, 6, 32'hA5, "R4 gpio_out pins");
        rd(1, 32'hA5, "R4 out readback");
        wr(2, 32'h0000_0002);
        rd(2, 32'h2, "R4 mask readback");

        // R2 partial and misaligned writes
        wr(1, 32'h3C, 4'h3);
        rd(1, 32'hA5, "R2 partial be ignored");
        wr(1, 32'h3C, 4'hF, 2'b01);
        rd(1, 32'hA5, "R2 misaligned ignored");
        expect_at(cyc, 6, 32'hA5, "R2 gpio_out unchanged");
        step();

        // R1 reserved / R4 input read-only / R11 caps read-only
        wr(3, 32'hDEAD_BEEF);
        rd(3, 32'h0, "R1 reserved idx3");
        wr(12, 32'h1234);
        rd(12, 32'h0, "R1 reserved idx12");
        wr(0, 32'hFF);
        rd(0, 32'h1, "R4 input ignores writes");
        wr(14, 32'hFFFF_FFFF);
        expect_at(wcyc + 1, 5, 0, "R11 caps write no reset_req");
        rd(14, 32'h0, "R11 caps read-only");

        // R5 gpio change interrupt, enabled bit 1
        k = cyc;
        gpio_in = 8'h03;
        expect_at(k + 2, 3, 0, "R5 irq not early");
        expect_at(k + 3, 3, 1, "R5 irq on enabled change");
        expect_at(k + 4, 3, 0, "R5 irq single pulse");
        step(); step();
        rd(0, 32'h3, "R4 synchronized input");
        repeat (4) step();
        k = cyc;
        gpio_in = 8'h07;
        expect_at(k + 3, 3, 0, "R5 masked bit no irq");
        repeat (6) step();

        // R6/R7 timer0 one-shot
        wr(5, 32'd5);
        wr(6, 32'd0);
        wr(4, 32'h1);
        k = wcyc;
        rd(6, 32'd0, "R6 counter after enable");
        rd(6, 32'd1, "R6 counter increments");
        expect_at(k + 6, 1, 0, "R6 irq not early");
        expect_at(k + 7, 1, 1, "R6 irq on hit");
        expect_at(k + 8, 1, 0, "R6 irq single pulse");
        repeat (9) step();
        rd(4, 32'h0, "R7 enable cleared");
        rd(6, 32'd5, "R7 counter holds at compare");

        // R8 timer1 auto-restart
        wr(9, 32'd3);
        wr(10, 32'd0);
        wr(8, 32'h3);
        k = wcyc;
        expect_at(k + 5, 2, 1, "R8 first irq");
        expect_at(k + 6, 2, 0, "R8 irq single pulse");
        repeat (4) step();
        rd(10, 32'd0, "R8 counter back to zero");
        rd(10, 32'd1, "R8 counter runs on");
        // R9 stop two cycles before the next hit
        wr(8, 32'h0);
        expect_at(k + 9, 2, 0, "R9 no irq once stopped");
        step();
        rd(10, 32'd3, "R9 frozen value");
        repeat (3) step();
        rd(10, 32'd3, "R9 still frozen");
        rd(8, 32'h0, "R9 control cleared by write");

        // R9 resume from loaded counter
        wr(10, 32'd100);
        wr(9, 32'd102);
        wr(8, 32'h1);
        k = wcyc;
        expect_at(k + 3, 2, 0, "R9 resume irq not early");
        expect_at(k + 4, 2, 1, "R9 resume irq C-S+2");
        repeat (6) step();
        rd(10, 32'd102, "R9 resumed count reached compare");

        // R10 shutdown code
        wr(13, 32'hABCD_000E);
        expect_at(wcyc + 1, 4, 1, "R10 shutdown pulse");
        expect_at(wcyc + 2, 4, 0, "R10 shutdown single");
        step();
        wr(13, 32'h0000_000F);
        expect_at(wcyc + 1, 4, 0, "R10 other code ignored");
        rd(13, 32'h1, "R10 status reads ready");

        // R11 reset request
        wr(15, 32'h0);
        expect_at(wcyc + 1, 5, 1, "R11 reset_req pulse");
        expect_at(wcyc + 2, 5, 0, "R11 reset_req single");
        step();
        rd(15, 32'h10014D31, "R11 ident unchanged");

        repeat (4) step();
        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule